// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block produces three pulse-width-modulated phases from a single shared carrier counter. Each phase owns a compare value, and one reload value sets the top of the carrier. The phases share the counter, so all three stay in step. Each phase drives a complementary high-side/low-side output pair. A programmable gap is inserted before either side of a pair turns on, so the two sides are never on together.

The counter advances once every two clocks. It runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Software writes reload and compare values into shadow registers. These values move into the working registers only at the period boundary, which is the same point where a one-clock interrupt pulse is raised. Software can therefore retune the period and duty cycle atomically right after that pulse. A small synchronous bus gives write and read access to the settings and exposes a read-only count-direction bit.

The carrier is sequenced by a three-state machine:
- IDLE: stopped, count held at 0.
- UP: counting up.
- DOWN: counting down, center-aligned mode only.

Its transitions are:
- start: IDLE→UP when the enable bit is seen set.
- edge wrap: UP→UP with the count returning to 0 after reaching reload.
- top turn: UP→DOWN at reload, in center-aligned mode.
- bottom wrap: DOWN→UP when a count of 0 is left.
- stop: UP or DOWN→IDLE when the enable bit is seen clear.

Top module: `pwm3_wavegen`

## Requirements
- R1: After reset, all PWM outputs and the interrupt are low, and every register reads back 0.
- R2: Bus writes take effect on the clock edge where `bus_wr` is high. Address 0 is control: bits 7:0 hold the dead time, bit 8 selects the mode (1 = center-aligned), bit 9 is the enable, and bit 10 is the read-only direction bit. Address 1 is reload. Addresses 2, 3 and 4 are the compares of phases 0, 1 and 2. `bus_rdata` shows the register selected by `bus_addr` one clock later.
- R3: The count changes at most once every two clocks, by +1, by −1 or by a return to 0, and never exceeds the active reload. In edge-aligned mode it runs 0..reload and then wraps, so the period is 2·(reload+1) clocks.
- R4: In edge-aligned mode, a phase's raw drive is on while count < compare. With a dead time of 0, its high-side output is on for 2·compare clocks per period.
- R5: In center-aligned mode the count runs 0 up to reload and back down to 0, giving a period of 2·(2·reload+1) clocks. The high side is on for 4·compare clocks per period when the dead time is 0.
- R6: The direction bit reads 1 exactly while the counter is counting down, which happens only in center-aligned mode: 2·reload clocks per period.
- R7: Writes to reload and compare values, and the mode bit, take effect only at the period boundary. A write landing on the boundary edge itself waits for the next boundary.
- R8: Every period boundary produces a `period_irq` pulse exactly one clock wide.
- R9: A side of a pair turns on only after the raw drive has held its new level for the programmed dead-time clocks. Each on-time is therefore shortened by the dead time, and high and low of a pair are never on together.
- R10: Clearing the enable bit returns the counter to 0, drives every output low within two clocks, and stops interrupts.
- R11: A compare of 0 keeps the high side off for the whole period. A compare equal to reload in edge-aligned mode keeps it on for all but 2 clocks of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pwm_hi | output | 3 | High-side output per phase |
| pwm_lo | output | 3 | Low-side output per phase |
| period_irq | output | 1 | One-clock pulse at each period boundary |

## Verification
The delicate coincidence is a bus write to the reload shadow landing on the very edge where the bottom or edge wrap copies the shadows into the working registers. The bench locks onto an interrupt pulse and counts clocks so that its write is sampled on the next wrap edge. It then expects one more period of the old length before the new length appears. A second overlap, the dead-time gap with the raw drive reversing, is judged every clock by the behavioural model and by the pair-exclusion property.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_RELOAD = 1;
    localparam int ADDR_CMP0   = 2;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs #(
    parameter int CW  = 16,
    parameter int DTW = 8,
    parameter int NPH = 3,
    parameter int AW  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [AW-1:0]            addr,
    input  logic [CW-1:0]            wdata,
    input  logic                     dir_down,
    output logic [DTW-1:0]           dead_time,
    output logic                     center_sh,
    output logic                     enable,
    output logic [CW-1:0]            rel_sh,
    output logic [NPH-1:0][CW-1:0]   cmp_sh,
    output logic [CW-1:0]            rdata
);
    import pwm3_pkg::*;

    localparam int MODE_BIT = DTW;
    localparam int EN_BIT   = DTW + 1;
    localparam int DIR_BIT  = DTW + 2;

    logic [DTW-1:0]         dt_q;
    logic                   center_q;
    logic                   en_q;
    logic [CW-1:0]          rel_q;
    logic [NPH-1:0][CW-1:0] cmp_q;
    logic [CW-1:0]          rd_n;
    logic [CW-1:0]          rd_q;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_q     <= '0;
            center_q <= 1'b0;
            en_q     <= 1'b0;
            rel_q    <= '0;
            cmp_q    <= '0;
        end else if (wr) begin
            if (addr == AW'(ADDR_CTRL)) begin
                dt_q     <= wdata[DTW-1:0];
                center_q <= wdata[MODE_BIT];
                en_q     <= wdata[EN_BIT];
            end
            if (addr == AW'(ADDR_RELOAD)) begin
                rel_q <= wdata;
            end
            for (int i = 0; i < NPH; i++) begin
                if (addr == AW'(ADDR_CMP0 + i)) begin
                    cmp_q[i] <= wdata;
                end
            end
        end
    end

    // read selection
    always_comb begin
        rd_n = '0;
        if (addr == AW'(ADDR_CTRL)) begin
            rd_n[DTW-1:0]  = dt_q;
            rd_n[MODE_BIT] = center_q;
            rd_n[EN_BIT]   = en_q;
            rd_n[DIR_BIT]  = dir_down;
        end
        if (addr == AW'(ADDR_RELOAD)) begin
            rd_n = rel_q;
        end
        for (int i = 0; i < NPH; i++) begin
            if (addr == AW'(ADDR_CMP0 + i)) begin
                rd_n = cmp_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_n;
        end
    end

    assign dead_time = dt_q;
    assign center_sh = center_q;
    assign enable    = en_q;
    assign rel_sh    = rel_q;
    assign cmp_sh    = cmp_q;
    assign rdata     = rd_q;

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     center_sh,
    input  logic [CW-1:0]            rel_sh,
    input  logic [NPH-1:0][CW-1:0]   cmp_sh,
    output logic [NPH-1:0]           raw,
    output logic                     run,
    output logic                     dir_down,
    output logic                     irq,
    output pwm3_pkg::tb_state_e      state_o,
    output logic [CW-1:0]            cnt_o,
    output logic [CW-1:0]            rel_o,
    output logic                     center_o
);
    import pwm3_pkg::*;

    localparam logic [CW-1:0] ONE = CW'(1);

    tb_state_e              state_q, state_n;
    logic [CW-1:0]          cnt_q, cnt_n;
    logic                   pre_q, pre_n;
    logic                   load, wrap;
    logic [CW-1:0]          rel_q;
    logic [NPH-1:0][CW-1:0] cmp_q;
    logic                   center_q;
    logic                   irq_q;

    // next-state and count
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        pre_n   = 1'b0;
        load    = 1'b0;
        wrap    = 1'b0;
        unique case (state_q)
            TB_IDLE: begin
                if (enable) begin
                    state_n = TB_UP;   // start
                    cnt_n   = '0;
                    load    = 1'b1;
                end
            end
            TB_UP: begin
                if (!enable) begin
                    state_n = TB_IDLE; // stop
                    cnt_n   = '0;
                end else begin
                    pre_n = ~pre_q;
                    if (pre_q) begin
                        if (cnt_q < rel_q) begin
                            cnt_n = cnt_q + ONE;
                        end else if (center_q && (rel_q != '0)) begin
                            state_n = TB_DOWN; // top turn
                            cnt_n   = cnt_q - ONE;
                        end else begin
                            cnt_n = '0;        // edge wrap
                            wrap  = 1'b1;
                        end
                    end
                end
            end
            TB_DOWN: begin
                if (!enable) begin
                    state_n = TB_IDLE; // stop
                    cnt_n   = '0;
                end else begin
                    pre_n = ~pre_q;
                    if (pre_q) begin
                        if (cnt_q == '0) begin
                            state_n = TB_UP;   // bottom wrap
                            wrap    = 1'b1;
                        end else begin
                            cnt_n = cnt_q - ONE;
                        end
                    end
                end
            end
            default: begin
                state_n = TB_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_IDLE;
            cnt_q   <= '0;
            pre_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            pre_q   <= pre_n;
        end
    end

    // working registers and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q    <= '0;
            cmp_q    <= '0;
            center_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (load || wrap) begin
                rel_q    <= rel_sh;
                cmp_q    <= cmp_sh;
                center_q <= center_sh;
            end
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_raw
        assign raw[g] = (state_q != TB_IDLE) && (cnt_q < cmp_q[g]);
    end

    assign run      = (state_q != TB_IDLE);
    assign dir_down = (state_q == TB_DOWN);
    assign irq      = irq_q;
    assign state_o  = state_q;
    assign cnt_o    = cnt_q;
    assign rel_o    = rel_q;
    assign center_o = center_q;

endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           raw,
    input  logic [DTW-1:0] dead_time,
    output logic           hi,
    output logic           lo
);
    logic           prev_q;
    logic [DTW-1:0] age_q, age_n;
    logic           settled;
    logic           hi_q, lo_q;

    // clocks the raw level has held since its last change
    always_comb begin
        if (!run || (raw != prev_q)) begin
            age_n = '0;
        end else if (age_q != {DTW{1'b1}}) begin
            age_n = age_q + DTW'(1);
        end else begin
            age_n = age_q;
        end
        settled = (age_n >= dead_time);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            age_q  <= '0;
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
        end else begin
            prev_q <= raw;
            age_q  <= age_n;
            hi_q   <= run &  raw & settled;
            lo_q   <= run & ~raw & settled;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

endmodule

// File: rtl/pwm3_wavegen.sv
module pwm3_wavegen #(
    parameter int CW  = 16,
    parameter int DTW = 8,
    parameter int NPH = 3,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NPH-1:0] pwm_hi,
    output logic [NPH-1:0] pwm_lo,
    output logic           period_irq
);
    import pwm3_pkg::*;

    logic [DTW-1:0]         dead_time;
    logic                   center_sh;
    logic                   enable;
    logic [CW-1:0]          rel_sh;
    logic [NPH-1:0][CW-1:0] cmp_sh;
    logic [NPH-1:0]         raw;
    logic                   run;
    logic                   dir_down;
    tb_state_e              tb_state;
    logic [CW-1:0]          tb_cnt;
    logic [CW-1:0]          tb_rel;
    logic                   tb_center;

    pwm3_regs #(.CW(CW), .DTW(DTW), .NPH(NPH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .dir_down  (dir_down),
        .dead_time (dead_time),
        .center_sh (center_sh),
        .enable    (enable),
        .rel_sh    (rel_sh),
        .cmp_sh    (cmp_sh),
        .rdata     (bus_rdata)
    );

    pwm3_timebase #(.CW(CW), .NPH(NPH)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .center_sh (center_sh),
        .rel_sh    (rel_sh),
        .cmp_sh    (cmp_sh),
        .raw       (raw),
        .run       (run),
        .dir_down  (dir_down),
        .irq       (period_irq),
        .state_o   (tb_state),
        .cnt_o     (tb_cnt),
        .rel_o     (tb_rel),
        .center_o  (tb_center)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        pwm3_deadband #(.DTW(DTW)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .raw       (raw[g]),
            .dead_time (dead_time),
            .hi        (pwm_hi[g]),
            .lo        (pwm_lo[g])
        );
    end

endmodule

// File: rtl/pwm3_chk.sv
module pwm3_chk #(
    parameter int CW  = 16,
    parameter int NPH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NPH-1:0]      pwm_hi,
    input logic [NPH-1:0]      pwm_lo,
    input logic                period_irq,
    input pwm3_pkg::tb_state_e st,
    input logic [CW-1:0]       cnt,
    input logic [CW-1:0]       rel,
    input logic                center
);
    import pwm3_pkg::*;

    localparam logic [CW-1:0] ONE = CW'(1);

    // R9
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_hi & pwm_lo) == '0);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> !period_irq);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TB_IDLE) |=> (pwm_hi == '0 && pwm_lo == '0 && !period_irq));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TB_IDLE) |-> (cnt <= rel));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TB_IDLE && $past(st) != TB_IDLE && cnt != $past(cnt)) |->
        (cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE || cnt == '0));

    // R6
    down_center_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TB_DOWN) |-> center);

endmodule

bind pwm3_wavegen pwm3_chk #(.CW(CW), .NPH(NPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_hi     (pwm_hi),
    .pwm_lo     (pwm_lo),
    .period_irq (period_irq),
    .st         (tb_state),
    .cnt        (tb_cnt),
    .rel        (tb_rel),
    .center     (tb_center)
);

// File: tb/tb_pwm3_wavegen.sv
module tb_pwm3_wavegen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  pwm_hi;
    logic [2:0]  pwm_lo;
    logic        period_irq;

    int checks = 0;
    int errors = 0;

    pwm3_wavegen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pwm_hi     (pwm_hi),
        .pwm_lo     (pwm_lo),
        .period_irq (period_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st = 0;           // 0 stopped, 1 rising, 2 falling
    int  m_cnt = 0;
    bit  m_pre = 0;
    bit  m_en = 0, m_ctr = 0, m_ctr_a = 0;
    int  m_dt = 0;
    int  sh_rel = 0, m_rel_a = 0;
    int  sh_cmp[3] = '{0, 0, 0};
    int  m_cmp_a[3] = '{0, 0, 0};
    int  m_age[3] = '{0, 0, 0};
    bit  m_prev[3] = '{0, 0, 0};
    bit [2:0] m_hi = '0, m_lo = '0;
    bit  m_irq = 0;
    int  m_rd = 0;

    always @(posedge clk) begin
        bit run, raw, wrap;
        int na;
        if (rst_n) begin
            case (bus_addr)
                3'd0: m_rd = m_dt + (int'(m_ctr) << 8) + (int'(m_en) << 9) + ((m_st == 2) ? 1024 : 0);
                3'd1: m_rd = sh_rel;
                3'd2: m_rd = sh_cmp[0];
                3'd3: m_rd = sh_cmp[1];
                3'd4: m_rd = sh_cmp[2];
                default: m_rd = 0;
            endcase
            run = (m_st != 0);
            for (int i = 0; i < 3; i++) begin
                raw = run && (m_cnt < m_cmp_a[i]);
                if (!run || raw != m_prev[i]) na = 0;
                else na = (m_age[i] < 255) ? m_age[i] + 1 : 255;
                m_hi[i] = run && raw && (na >= m_dt);
                m_lo[i] = run && !raw && (na >= m_dt);
                m_prev[i] = raw;
                m_age[i] = na;
            end
            m_irq = 0;
            wrap = 0;
            if (m_st == 0) begin
                if (m_en) begin
                    m_st = 1; m_cnt = 0; m_pre = 0;
                    m_rel_a = sh_rel; m_cmp_a = sh_cmp; m_ctr_a = m_ctr;
                end
            end else if (!m_en) begin
                m_st = 0; m_cnt = 0; m_pre = 0;
            end else if (!m_pre) begin
                m_pre = 1;
            end else begin
                m_pre = 0;
                if (m_st == 1) begin
                    if (m_cnt < m_rel_a) m_cnt++;
                    else if (m_ctr_a && m_rel_a > 0) begin m_st = 2; m_cnt--; end
                    else begin m_cnt = 0; wrap = 1; end
                end else begin
                    if (m_cnt == 0) begin m_st = 1; wrap = 1; end
                    else m_cnt--;
                end
                if (wrap) begin
                    m_irq = 1;
                    m_rel_a = sh_rel; m_cmp_a = sh_cmp; m_ctr_a = m_ctr;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        m_dt = int'(bus_wdata[7:0]);
                        m_ctr = bus_wdata[8];
                        m_en = bus_wdata[9];
                    end
                    3'd1: sh_rel = int'(bus_wdata);
                    3'd2: sh_cmp[0] = int'(bus_wdata);
                    3'd3: sh_cmp[1] = int'(bus_wdata);
                    3'd4: sh_cmp[2] = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(pwm_hi == m_hi, "R4", "high-side outputs", int'(pwm_hi), int'(m_hi));
            check(pwm_lo == m_lo, "R9", "low-side outputs", int'(pwm_lo), int'(m_lo));
            check(period_irq == m_irq, "R8", "period_irq", int'(period_irq), int'(m_irq));
            check(int'(bus_rdata) == m_rd, "R2", "read data", int'(bus_rdata), m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        bus_addr = 3'(a);
        @(negedge clk);
        d = int'(bus_rdata);
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!period_irq);
    endtask

    task automatic to_next(output int c);
        c = 0;
        do begin @(negedge clk); c++; end while (!period_irq);
    endtask

    task automatic count_on(input int idx, input bit low_side, input int n, output int c);
        wait_irq();
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (low_side ? pwm_lo[idx] : pwm_hi[idx]) c++;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        int v, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(pwm_hi == 0 && pwm_lo == 0, "R1", "outputs after reset", int'({pwm_hi, pwm_lo}), 0);
        check(!period_irq, "R1", "irq after reset", int'(period_irq), 0);
        for (int a = 0; a < 5; a++) begin
            bus_read(a, v);
            check(v == 0, "R1", $sformatf("register %0d after reset", a), v, 0);
        end

        // edge-aligned, reload 9, compares 3 / 0 / 9, no dead time
        bus_write(1, 9);
        bus_write(2, 3);
        bus_write(3, 0);
        bus_write(4, 9);
        bus_write(0, 16'h0200);
        repeat (3) wait_irq();
        bus_read(1, v);
        check(v == 9, "R2", "reload readback", v, 9);
        bus_read(0, v);
        check(v == 16'h0200, "R6", "control readback in edge mode", v, 16'h0200);

        wait_irq();
        to_next(c);
        check(c == 20, "R3", "edge period clocks", c, 20);
        count_on(0, 0, 20, c);
        check(c == 6, "R4", "phase0 high clocks", c, 6);
        count_on(0, 1, 20, c);
        check(c == 14, "R9", "phase0 low clocks with zero dead time", c, 14);
        count_on(1, 0, 20, c);
        check(c == 0, "R11", "compare 0 high clocks", c, 0);
        count_on(2, 0, 20, c);
        check(c == 18, "R11", "compare=reload high clocks", c, 18);

        // R7: shadow update in mid period
        wait_irq();
        bus_write(1, 5);
        bus_write(4, 5);
        to_next(c);
        check(c + 4 == 20, "R7", "period still old after write", c + 4, 20);
        to_next(c);
        check(c == 12, "R7", "period after boundary", c, 12);

        // R7: write landing exactly on the wrap edge
        wait_irq();
        repeat (10) @(negedge clk);
        bus_write(1, 7);
        to_next(c);
        check(c == 12, "R7", "boundary-coincident write deferred", c, 12);
        to_next(c);
        check(c == 16, "R7", "new period one boundary later", c, 16);

        // center-aligned, reload 8
        bus_write(1, 8);
        bus_write(0, 16'h0300);
        repeat (3) wait_irq();
        to_next(c);
        check(c == 34, "R5", "center period clocks", c, 34);
        count_on(0, 0, 34, c);
        check(c == 12, "R5", "phase0 high clocks center", c, 12);
        count_on(0, 1, 34, c);
        check(c == 22, "R5", "phase0 low clocks center", c, 22);

        // R6: direction bit sampled over one period
        @(negedge clk);
        bus_addr = 3'd0;
        wait_irq();
        c = 0;
        repeat (34) begin
            @(negedge clk);
            if (bus_rdata[10]) c++;
        end
        check(c == 16, "R6", "down-count clocks per period", c, 16);

        // R9: dead time of 3
        bus_write(0, 16'h0303);
        repeat (2) wait_irq();
        count_on(0, 0, 34, c);
        check(c == 9, "R9", "phase0 high clocks with dead time", c, 9);
        count_on(0, 1, 34, c);
        check(c == 19, "R9", "phase0 low clocks with dead time", c, 19);
        count_on(1, 1, 34, c);
        check(c == 34, "R11", "compare 0 low side always on", c, 34);

        // R10: disable
        bus_write(0, 16'h0003);
        repeat (2) @(negedge clk);
        c = 0;
        repeat (40) begin
            @(negedge clk);
            if (pwm_hi != 0 || pwm_lo != 0 || period_irq) c++;
        end
        check(c == 0, "R10", "active clocks after disable", c, 0);
        bus_read(0, v);
        check(v == 16'h0003, "R10", "control after disable", v, 16'h0003);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule